// File: doc/BRIEF.md
# Multi-CPU Interrupt Acknowledge Unit

This block is the acknowledge side of a small programmable interrupt controller that serves several processors. Each interrupt source holds a vector, a priority, a trigger sense (edge or level) and a mask of destination CPUs. Each CPU holds a raised set, an in-service set and a current task priority (CTPR). When a source fires, it is raised on every CPU in its destination mask. A CPU's interrupt line is high while its best raised source is worth taking.

A CPU reads its acknowledge offset to claim work. The unit drops that CPU's interrupt line and picks the best raised source. It then checks the source once more against its activity bit and the CTPR. The source is either moved into the in-service set, with its vector returned, or dropped, with the spurious vector returned. Sources in the inter-processor range can target several CPUs. Each acknowledge removes the reading CPU from the mask. If other CPUs remain and the source is edge-triggered, the source is raised again on them and its activity is restored, so those CPUs still see a valid interrupt. Reading the end-of-interrupt offset retires the highest in-service source and returns zero.

The control is a three-state machine:
- IDLE accepts reads. An acknowledge read moves it to EVAL; any other read is answered from IDLE.
- EVAL commits the acknowledge and returns its result. It goes to RETRIG for a multicast edge-triggered inter-processor source that still has destinations, and to IDLE otherwise.
- RETRIG raises the source on the remaining CPUs, sets its activity again and returns to IDLE.

Top module: `iack_unit`

## Requirements
- R1: After reset every raised set and in-service set is empty, every CTPR is 0, every source is edge-triggered with an empty destination mask, and `irq_out`, `rd_valid` are low.
- R2: Delivery happens when an edge source (`cfg_level`=0) sees a rising `src_in`, or when a level source (`cfg_level`=1) has `src_in` high, provided the source's activity bit is clear and its destination mask (bit c = CPU c) is non-zero. Delivery sets the activity bit and raises the source on every CPU in the mask. `irq_out[c]` goes high on the second clock edge that samples the input.
- R3: The unit accepts a read at offset 0xA0 only in IDLE. The reading CPU's `irq_out` is low from the edge that accepts the read until the edge after `rd_valid`, and `rd_valid` comes on the second edge after acceptance.
- R4: The acknowledge picks the raised source with the highest priority; on equal priority the lowest index wins. With nothing raised, the result is `spur_vec` (zero-extended).
- R5: If the picked source's activity bit is clear, or its priority is not strictly above that CPU's CTPR, its activity is cleared and the result is `spur_vec`. Otherwise the source enters the CPU's in-service set and the result is its vector (zero-extended). No other event adds to an in-service set.
- R6: A picked source always leaves the reading CPU's raised set. For an edge source, activity and pending are cleared, so only a new rising edge raises it again. A level source keeps pending while its input is high, so it is raised again once its activity is clear. A falling level input clears activity.
- R7: For sources 12 to 15, an acknowledge clears the reader's bit in the destination mask. If bits remain and the source is edge-triggered, the source is raised again on the remaining CPUs and its activity is set.
- R8: A read at offset 0xB0 returns 0 one edge after acceptance and removes the reading CPU's highest-priority in-service source (lowest index on ties).
- R9: A read at any offset other than 0xA0 and 0xB0 returns all ones one edge after acceptance.
- R10: `rd_en` outside IDLE is ignored and yields no result.
- R11: `irq_out[c]` is high only when CPU c's best raised source is active and its priority is strictly above both that CPU's CTPR and its highest in-service priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | NSRC | Source request lines |
| cfg_we | input | 1 | Write source configuration |
| cfg_idx | input | $clog2(NSRC) | Source to configure |
| cfg_vec | input | VW | Vector to store |
| cfg_prio | input | PW | Priority to store |
| cfg_level | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| cfg_dest | input | NCPU | Destination CPU mask |
| ctpr_we | input | 1 | Write a CTPR |
| ctpr_cpu | input | CW | CPU whose CTPR is written |
| ctpr_val | input | PW | New CTPR value |
| spur_vec | input | VW | Spurious vector |
| rd_en | input | 1 | Register read request |
| rd_cpu | input | CW | Reading CPU |
| rd_addr | input | 8 | Read offset |
| rd_valid | output | 1 | Read result strobe |
| rd_data | output | 32 | Read result |
| irq_out | output | NCPU | Per-CPU interrupt line |

## Verification
A wrong raised or in-service bit shows up at `irq_out` on the next edge. It also changes the next acknowledge result, either by returning a different vector or by returning the spurious vector where a vector was due. A wrong activity bit or a wrong destination mask shows up one acknowledge later. For a multicast inter-processor source, the second CPU then reads the spurious vector instead of the source's vector. A source that was not cleared on acknowledge shows up as an interrupt line that stays high, or goes high again, without a new input edge.

// File: rtl/iack_pkg.sv
package iack_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_EVAL   = 2'd1,
        ST_RETRIG = 2'd2
    } iack_state_e;

    localparam logic [7:0] OFS_ACK = 8'hA0;
    localparam logic [7:0] OFS_EOI = 8'hB0;
endpackage

// File: rtl/iack_pick.sv
module iack_pick #(
    parameter int N  = 16,
    parameter int PW = 4,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]         req,
    input  logic [N-1:0][PW-1:0] prio,
    output logic                 found,
    output logic [IW-1:0]        idx,
    output logic [PW-1:0]        best
);
    // Linear scan; a strictly greater priority replaces, so the lowest index wins ties.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        best  = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && (!found || (prio[i] > best))) begin
                found = 1'b1;
                idx   = IW'(i);
                best  = prio[i];
            end
        end
    end
endmodule

// File: rtl/iack_src_bank.sv
module iack_src_bank #(
    parameter int NSRC = 16,
    parameter int NCPU = 2,
    parameter int PW   = 4,
    parameter int VW   = 8,
    localparam int IW  = $clog2(NSRC),
    localparam int CW  = (NCPU > 1) ? $clog2(NCPU) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NSRC-1:0]           src_in,
    input  logic                      cfg_we,
    input  logic [IW-1:0]             cfg_idx,
    input  logic [VW-1:0]             cfg_vec,
    input  logic [PW-1:0]             cfg_prio,
    input  logic                      cfg_level,
    input  logic [NCPU-1:0]           cfg_dest,
    input  logic [NSRC-1:0]           clr_act,
    input  logic [NSRC-1:0]           set_act,
    input  logic [NSRC-1:0]           clr_pend,
    input  logic                      dest_clr_en,
    input  logic [IW-1:0]             dest_clr_idx,
    input  logic [CW-1:0]             dest_clr_cpu,
    output logic [NSRC-1:0]           act,
    output logic [NSRC-1:0][PW-1:0]   prio,
    output logic [NSRC-1:0][VW-1:0]   vec,
    output logic [NSRC-1:0]           level,
    output logic [NSRC-1:0][NCPU-1:0] dest,
    output logic [NSRC-1:0]           deliver
);
    for (genvar i = 0; i < NSRC; i++) begin : g_src
        logic prev_q, pend_q, pend_nx, trig;

        assign trig       = src_in[i] & ~prev_q;
        assign pend_nx    = level[i] ? src_in[i] : ((pend_q & ~clr_pend[i]) | trig);
        assign deliver[i] = pend_nx & ~act[i] & (|dest[i]);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prev_q   <= 1'b0;
                pend_q   <= 1'b0;
                act[i]   <= 1'b0;
                prio[i]  <= '0;
                vec[i]   <= '0;
                level[i] <= 1'b0;
                dest[i]  <= '0;
            end else begin
                prev_q <= src_in[i];
                pend_q <= pend_nx;
                if (level[i] && !src_in[i])
                    act[i] <= 1'b0;
                else if (deliver[i] || set_act[i])
                    act[i] <= 1'b1;
                else if (clr_act[i])
                    act[i] <= 1'b0;
                if (cfg_we && cfg_idx == IW'(i)) begin
                    prio[i]  <= cfg_prio;
                    vec[i]   <= cfg_vec;
                    level[i] <= cfg_level;
                    dest[i]  <= cfg_dest;
                end else if (dest_clr_en && dest_clr_idx == IW'(i)) begin
                    dest[i][dest_clr_cpu] <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/iack_unit.sv
module iack_unit #(
    parameter int NSRC     = 16,
    parameter int NCPU     = 2,
    parameter int IPI_BASE = 12,
    parameter int NIPI     = 4,
    parameter int PW       = 4,
    parameter int VW       = 8,
    localparam int IW      = $clog2(NSRC),
    localparam int CW      = (NCPU > 1) ? $clog2(NCPU) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_in,
    input  logic            cfg_we,
    input  logic [IW-1:0]   cfg_idx,
    input  logic [VW-1:0]   cfg_vec,
    input  logic [PW-1:0]   cfg_prio,
    input  logic            cfg_level,
    input  logic [NCPU-1:0] cfg_dest,
    input  logic            ctpr_we,
    input  logic [CW-1:0]   ctpr_cpu,
    input  logic [PW-1:0]   ctpr_val,
    input  logic [VW-1:0]   spur_vec,
    input  logic            rd_en,
    input  logic [CW-1:0]   rd_cpu,
    input  logic [7:0]      rd_addr,
    output logic            rd_valid,
    output logic [31:0]     rd_data,
    output logic [NCPU-1:0] irq_out
);
    import iack_pkg::*;

    localparam logic [IW:0] IPI_LO = (IW+1)'(IPI_BASE);
    localparam logic [IW:0] IPI_HI = (IW+1)'(IPI_BASE + NIPI);

    iack_state_e st, st_nx;
    logic [CW-1:0]   cpu_q;
    logic            found_q;
    logic [IW-1:0]   idx_q;
    logic [NCPU-1:0] rem_q, rem;
    logic            is_ipi, ack_ok, dest_clr_en;

    logic [NSRC-1:0]           act, level, deliver, clr_act_v, set_act_v, clr_pend_v;
    logic [NSRC-1:0][PW-1:0]   prio;
    logic [NSRC-1:0][VW-1:0]   vec;
    logic [NSRC-1:0][NCPU-1:0] dest;

    logic [NCPU-1:0][NSRC-1:0] raised, insvc, clr_r, set_r, set_isr, clr_isr, retrig_set;
    logic [NCPU-1:0][PW-1:0]   ctpr, r_prio, s_prio;
    logic [NCPU-1:0][IW-1:0]   r_idx, s_idx;
    logic [NCPU-1:0]           r_found, s_found, want, hold;

    iack_src_bank #(.NSRC(NSRC), .NCPU(NCPU), .PW(PW), .VW(VW)) i_bank (
        .clk(clk), .rst_n(rst_n), .src_in(src_in),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_vec(cfg_vec), .cfg_prio(cfg_prio),
        .cfg_level(cfg_level), .cfg_dest(cfg_dest),
        .clr_act(clr_act_v), .set_act(set_act_v), .clr_pend(clr_pend_v),
        .dest_clr_en(dest_clr_en), .dest_clr_idx(idx_q), .dest_clr_cpu(cpu_q),
        .act(act), .prio(prio), .vec(vec), .level(level), .dest(dest), .deliver(deliver)
    );

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        iack_pick #(.N(NSRC), .PW(PW)) i_pick_raised (
            .req(raised[c]), .prio(prio), .found(r_found[c]), .idx(r_idx[c]), .best(r_prio[c])
        );
        iack_pick #(.N(NSRC), .PW(PW)) i_pick_insvc (
            .req(insvc[c]), .prio(prio), .found(s_found[c]), .idx(s_idx[c]), .best(s_prio[c])
        );
        assign want[c] = r_found[c] && act[r_idx[c]] && (r_prio[c] > ctpr[c])
                         && (!s_found[c] || (r_prio[c] > s_prio[c]));
        assign hold[c] = ((st == ST_IDLE) && rd_en && (rd_addr == OFS_ACK) && (rd_cpu == CW'(c)))
                         || ((st == ST_EVAL) && (cpu_q == CW'(c)));

        // R5: nothing but a committed acknowledge adds to an in-service set
        assert_isr_only_on_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(st) != ST_EVAL) |-> ((insvc[c] & ~$past(insvc[c])) == '0));
    end

    always_comb begin
        for (int c = 0; c < NCPU; c++)
            for (int i = 0; i < NSRC; i++)
                set_r[c][i] = (deliver[i] & dest[i][c]) | retrig_set[c][i];
    end

    // Next state and commit controls
    always_comb begin
        st_nx       = st;
        ack_ok      = 1'b0;
        dest_clr_en = 1'b0;
        clr_act_v   = '0;
        set_act_v   = '0;
        clr_pend_v  = '0;
        clr_r       = '0;
        set_isr     = '0;
        clr_isr     = '0;
        retrig_set  = '0;
        rem         = dest[idx_q] & ~(NCPU'(1) << cpu_q);
        is_ipi      = ({1'b0, idx_q} >= IPI_LO) && ({1'b0, idx_q} < IPI_HI);
        unique case (st)
            ST_IDLE: begin
                if (rd_en) begin
                    if (rd_addr == OFS_ACK)
                        st_nx = ST_EVAL;
                    else if (rd_addr == OFS_EOI && s_found[rd_cpu])
                        clr_isr[rd_cpu][s_idx[rd_cpu]] = 1'b1;
                end
            end
            ST_EVAL: begin
                st_nx = ST_IDLE;
                if (found_q) begin
                    ack_ok = act[idx_q] && (prio[idx_q] > ctpr[cpu_q]);
                    clr_r[cpu_q][idx_q] = 1'b1;
                    if (ack_ok)
                        set_isr[cpu_q][idx_q] = 1'b1;
                    if (!ack_ok || !level[idx_q])
                        clr_act_v[idx_q] = 1'b1;
                    if (!level[idx_q])
                        clr_pend_v[idx_q] = 1'b1;
                    if (is_ipi) begin
                        dest_clr_en = 1'b1;
                        if ((|rem) && !level[idx_q])
                            st_nx = ST_RETRIG;
                    end
                end
            end
            ST_RETRIG: begin
                st_nx = ST_IDLE;
                set_act_v[idx_q] = 1'b1;
                for (int c = 0; c < NCPU; c++)
                    retrig_set[c][idx_q] = rem_q[c];
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    // State register and acknowledge context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            cpu_q   <= '0;
            found_q <= 1'b0;
            idx_q   <= '0;
            rem_q   <= '0;
        end else begin
            st <= st_nx;
            if (st == ST_IDLE && rd_en && rd_addr == OFS_ACK) begin
                cpu_q   <= rd_cpu;
                found_q <= r_found[rd_cpu];
                idx_q   <= r_idx[rd_cpu];
            end
            if (st == ST_EVAL)
                rem_q <= rem;
        end
    end

    // Per-CPU sets and task priorities
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raised <= '0;
            insvc  <= '0;
            ctpr   <= '0;
        end else begin
            raised <= (raised & ~clr_r) | set_r;
            insvc  <= (insvc & ~clr_isr) | set_isr;
            if (ctpr_we)
                ctpr[ctpr_cpu] <= ctpr_val;
        end
    end

    // Outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
            irq_out  <= '0;
        end else begin
            rd_valid <= 1'b0;
            irq_out  <= want & ~hold;
            if (st == ST_IDLE && rd_en && rd_addr != OFS_ACK) begin
                rd_valid <= 1'b1;
                rd_data  <= (rd_addr == OFS_EOI) ? 32'd0 : '1;
            end else if (st == ST_EVAL) begin
                rd_valid <= 1'b1;
                rd_data  <= (found_q && ack_ok) ? 32'(vec[idx_q]) : 32'(spur_vec);
            end
        end
    end

    assert_irq_low_in_eval_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_EVAL) |-> !irq_out[cpu_q]);

    assert_raised_dropped_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_EVAL && found_q && !(deliver[idx_q] && dest[idx_q][cpu_q]))
        |=> !raised[cpu_q][idx_q]);

    assert_eoi_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && rd_en && rd_addr == OFS_EOI) |=> (rd_valid && rd_data == 32'd0));

    assert_unmapped_ones_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && rd_en && rd_addr != OFS_ACK && rd_addr != OFS_EOI)
        |=> (rd_valid && rd_data == 32'hFFFF_FFFF));

    assert_one_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ($past(st) == ST_EVAL || ($past(st) == ST_IDLE && $past(rd_en))));
endmodule

// File: tb/test_iack_unit.sv
`timescale 1ns/1ps
module test_iack_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] src_in = '0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_idx = '0;
    logic [7:0]  cfg_vec = '0;
    logic [3:0]  cfg_prio = '0;
    logic        cfg_level = 1'b0;
    logic [1:0]  cfg_dest = '0;
    logic        ctpr_we = 1'b0;
    logic        ctpr_cpu = 1'b0;
    logic [3:0]  ctpr_val = '0;
    logic [7:0]  spur_vec = 8'h5A;
    logic        rd_en = 1'b0;
    logic        rd_cpu = 1'b0;
    logic [7:0]  rd_addr = '0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic [1:0]  irq_out;

    localparam logic [31:0] SPUR = 32'h0000_005A;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    iack_unit i_iack_unit (
        .clk(clk), .rst_n(rst_n), .src_in(src_in),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_vec(cfg_vec), .cfg_prio(cfg_prio),
        .cfg_level(cfg_level), .cfg_dest(cfg_dest),
        .ctpr_we(ctpr_we), .ctpr_cpu(ctpr_cpu), .ctpr_val(ctpr_val),
        .spur_vec(spur_vec), .rd_en(rd_en), .rd_cpu(rd_cpu), .rd_addr(rd_addr),
        .rd_valid(rd_valid), .rd_data(rd_data), .irq_out(irq_out)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act_v, input logic [31:0] exp_v);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act_v, exp_v);
        end
    endtask

    // Monitor: pops one expected item per result strobe
    always @(negedge clk) begin
        if (rst_n && rd_valid && !done) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R10 unexpected read result", rd_data, 32'hx);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(rd_data === e, t, rd_data, e);
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_idle();
        while (exp_q.size() != 0) @(posedge clk);
        cyc(2);
    endtask

    task automatic cfg(input int idx, input logic [7:0] v, input logic [3:0] p,
                       input logic lvl, input logic [1:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 4'(idx); cfg_vec = v; cfg_prio = p;
        cfg_level = lvl; cfg_dest = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_ctpr(input logic cpu, input logic [3:0] v);
        @(negedge clk);
        ctpr_we = 1'b1; ctpr_cpu = cpu; ctpr_val = v;
        @(negedge clk);
        ctpr_we = 1'b0;
        cyc(1);
    endtask

    task automatic pulse(input logic [15:0] m);
        @(negedge clk);
        src_in = src_in | m;
        @(negedge clk);
        src_in = src_in & ~m;
        cyc(2);
    endtask

    // Driver: issue a read and push the expected result
    task automatic rd(input logic cpu, input logic [7:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        rd_en = 1'b1; rd_cpu = cpu; rd_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        rd_en = 1'b0;
        wait_idle();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        chk(irq_out == 2'b00, "R1 irq after reset", 32'(irq_out), 0);
        chk(rd_valid == 1'b0, "R1 rd_valid after reset", 32'(rd_valid), 0);
        rd(0, 8'hA0, SPUR, "R1 R4 ack with empty raised set");
        rd(1, 8'h10, 32'hFFFF_FFFF, "R9 unmapped offset");
        rd(0, 8'hB0, 32'd0, "R8 eoi returns zero");

        // Priority and tie ordering on CPU0
        cfg(3, 8'h23, 4'd5, 1'b0, 2'b01);
        cfg(7, 8'h27, 4'd5, 1'b0, 2'b01);
        cfg(2, 8'h22, 4'd3, 1'b0, 2'b01);
        pulse(16'h008C);
        chk(irq_out[0] == 1'b1, "R2 irq0 raised", 32'(irq_out[0]), 1);
        chk(irq_out[1] == 1'b0, "R2 irq1 not in mask", 32'(irq_out[1]), 0);
        @(negedge clk);
        rd_en = 1'b1; rd_cpu = 1'b0; rd_addr = 8'hA0;
        exp_q.push_back(32'h23); tag_q.push_back("R4 tie picks lowest index");
        @(negedge clk);
        rd_en = 1'b0;
        chk(irq_out[0] == 1'b0, "R3 irq0 dropped on ack", 32'(irq_out[0]), 0);
        wait_idle();
        chk(irq_out[0] == 1'b0, "R11 equal in-service priority masks irq", 32'(irq_out[0]), 0);
        rd(0, 8'hA0, 32'h27, "R5 second prio-5 source served");
        rd(0, 8'hB0, 32'd0, "R8 eoi retires src3");
        chk(irq_out[0] == 1'b0, "R11 lower raised prio masked", 32'(irq_out[0]), 0);
        rd(0, 8'hB0, 32'd0, "R8 eoi retires src7");
        chk(irq_out[0] == 1'b1, "R8 irq returns after last eoi", 32'(irq_out[0]), 1);
        rd(0, 8'hA0, 32'h22, "R4 lower prio source next");
        rd(0, 8'hB0, 32'd0, "R8 eoi src2");
        chk(irq_out[0] == 1'b0, "R6 edge source not raised again", 32'(irq_out[0]), 0);
        rd(0, 8'hA0, SPUR, "R6 raised set emptied");

        // Task-priority revalidation on CPU1
        cfg(5, 8'h25, 4'd4, 1'b0, 2'b10);
        pulse(16'h0020);
        chk(irq_out[1] == 1'b1, "R2 irq1 raised", 32'(irq_out[1]), 1);
        set_ctpr(1, 4'd4);
        chk(irq_out[1] == 1'b0, "R11 ctpr masks equal prio", 32'(irq_out[1]), 0);
        rd(1, 8'hA0, SPUR, "R5 prio not above ctpr gives spurious");
        set_ctpr(1, 4'd0);
        cyc(1);
        chk(irq_out[1] == 1'b0, "R6 edge pending dropped", 32'(irq_out[1]), 0);
        rd(1, 8'hA0, SPUR, "R6 edge source gone");

        // Level source on CPU1
        cfg(6, 8'h26, 4'd6, 1'b1, 2'b10);
        set_ctpr(1, 4'd7);
        @(negedge clk); src_in[6] = 1'b1;
        cyc(3);
        chk(irq_out[1] == 1'b0, "R11 level below ctpr", 32'(irq_out[1]), 0);
        rd(1, 8'hA0, SPUR, "R5 level below ctpr spurious");
        set_ctpr(1, 4'd0);
        cyc(1);
        chk(irq_out[1] == 1'b1, "R6 level pending kept, raised again", 32'(irq_out[1]), 1);
        rd(1, 8'hA0, 32'h26, "R5 level vector");
        chk(irq_out[1] == 1'b0, "R3 irq1 low after level ack", 32'(irq_out[1]), 0);
        rd(1, 8'hB0, 32'd0, "R8 eoi level");
        chk(irq_out[1] == 1'b0, "R6 active level not raised again", 32'(irq_out[1]), 0);
        @(negedge clk); src_in[6] = 1'b0;
        cyc(2);
        @(negedge clk); src_in[6] = 1'b1;
        cyc(3);
        chk(irq_out[1] == 1'b1, "R2 level re-raise after fall", 32'(irq_out[1]), 1);
        @(negedge clk); src_in[6] = 1'b0;
        cyc(2);
        rd(1, 8'hA0, SPUR, "R5 inactive level spurious");

        // Multicast inter-processor source 13
        cfg(13, 8'h3D, 4'd7, 1'b0, 2'b11);
        pulse(16'h2000);
        chk(irq_out == 2'b11, "R2 ipi raised on both", 32'(irq_out), 3);
        rd(0, 8'hA0, 32'h3D, "R7 ipi first cpu");
        chk(irq_out[1] == 1'b1, "R7 ipi still pending on cpu1", 32'(irq_out[1]), 1);
        rd(1, 8'hA0, 32'h3D, "R7 ipi activity restored for cpu1");
        rd(0, 8'hB0, 32'd0, "R8 eoi ipi cpu0");
        rd(1, 8'hB0, 32'd0, "R8 eoi ipi cpu1");
        pulse(16'h2000);
        chk(irq_out == 2'b00, "R7 mask emptied by acks", 32'(irq_out), 0);

        // Read while busy
        @(negedge clk);
        rd_en = 1'b1; rd_cpu = 1'b0; rd_addr = 8'hA0;
        exp_q.push_back(SPUR); tag_q.push_back("R10 ack before busy read");
        @(negedge clk);
        rd_addr = 8'h10;
        @(negedge clk);
        rd_en = 1'b0;
        wait_idle();
        cyc(3);
        chk(exp_q.size() == 0, "R10 queue drained", exp_q.size(), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule